// File: doc/BRIEF.md
# Sequenced Pattern Trigger Engine

This block looks at sixteen already-thresholded channel bits and a small group of logic-input bits on every clock. From them it raises a single-cycle trigger pulse when a two-stage sequence completes. First a pattern event "A" must occur. After it, a second pattern event "B" must occur a programmed number of times. Each pattern gives every channel one of three choices: must be high, must be low, or ignored. Each pattern also has its own bit pattern for the logic group, and a switch that either pulls that group into the match or leaves it out entirely.

An event is an edge of the match. In Enter mode the event is the clock on which the inputs first fully match. In Exit mode it is the clock on which a full match is lost. If pattern B ignores every input, the block acts as a plain pattern trigger and fires on the A event directly. After each trigger a programmable hold-off interval suppresses all further triggering.

Configuration is presented on wide inputs and captured by a one-cycle write strobe. Any write returns the sequencer to waiting for A with its count cleared. The trigger pulse appears on the clock after the edge at which the completing event's input values are sampled.

Top module: `seqtrig_engine`

## Requirements
- R1: After reset `trig_out` is low, the sequencer waits for an A event, and all configuration is zero, so no trigger occurs.
- R2: A pattern matches when every channel whose care bit is 1 equals its value bit; channels with care bit 0 are ignored.
- R3: With the logic-group enable at 1, each logic bit whose logic care bit is 1 must equal its logic value bit; with the enable at 0, the logic inputs have no effect on the match.
- R4: With the exit flag at 0 (Enter), an event occurs on a clock whose inputs match when the previous clock's inputs did not.
- R5: With the exit flag at 1 (Exit), an event occurs on a clock whose inputs do not match when the previous clock's inputs did.
- R6: The trigger fires on the Nth B event after an A event. B events before the A event are ignored, and a B event on the same clock as the A event is not counted.
- R7: A programmed count of 0 behaves as 1. Further A events while B events are being counted do not restart the count.
- R8: When pattern B has every channel care bit at 0 and its logic group is disabled or has all logic care bits at 0, the A event fires the trigger directly.
- R9: `trig_out` is high for exactly one clock per trigger. For the next H clocks (H the hold-off value, 0 treated as 1) no event is acted upon and no trigger fires.
- R10: A configuration write returns the sequencer to waiting for A with the count cleared. The first clock after a reset or a write produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Strobe that captures all cfg_* inputs |
| cfg_a_care | input | NUM_CH | Pattern A channel care mask |
| cfg_a_value | input | NUM_CH | Pattern A channel required levels |
| cfg_a_lg_en | input | 1 | Pattern A includes the logic group |
| cfg_a_lg_care | input | LOGIC_W | Pattern A logic-bit care mask |
| cfg_a_lg_value | input | LOGIC_W | Pattern A logic-bit required levels |
| cfg_a_exit | input | 1 | Pattern A event mode: 0 Enter, 1 Exit |
| cfg_b_care | input | NUM_CH | Pattern B channel care mask |
| cfg_b_value | input | NUM_CH | Pattern B channel required levels |
| cfg_b_lg_en | input | 1 | Pattern B includes the logic group |
| cfg_b_lg_care | input | LOGIC_W | Pattern B logic-bit care mask |
| cfg_b_lg_value | input | LOGIC_W | Pattern B logic-bit required levels |
| cfg_b_exit | input | 1 | Pattern B event mode: 0 Enter, 1 Exit |
| cfg_count | input | CNT_W | Number of B events required (0 acts as 1) |
| cfg_holdoff | input | HOLD_W | Hold-off length in clocks (0 acts as 1) |
| ch_in | input | NUM_CH | Thresholded channel levels |
| lg_in | input | LOGIC_W | Logic-group input levels |
| trig_out | output | 1 | Single-cycle trigger pulse |

## Verification
The bench targets B edges that come while waiting for A and B edges that coincide with the A edge. A design that counted either would fire one B event early. It re-arms with an A event in the middle of counting; a design that restarted the count there would need extra B events. It also covers a count of zero, Exit-mode patterns that must ignore the entering edge, logic bits outside the care mask, and a disabled logic group. A configuration write is issued mid-count, and a design that kept the old count would fire without a new A event. Regular A events during hold-off show whether the block re-arms early or late, because the gap between triggers moves by whole event periods.

// File: rtl/seqtrig_pkg.sv
package seqtrig_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_A  = 2'd0,
        ST_COUNT_B = 2'd1,
        ST_HOLDOFF = 2'd2
    } seq_state_e;

    localparam int NUM_COND = 2;
    localparam int COND_A   = 0;
    localparam int COND_B   = 1;

endpackage

// File: rtl/seqtrig_match.sv
module seqtrig_match #(
    parameter int NUM_CH  = 16,
    parameter int LOGIC_W = 8
) (
    input  logic [NUM_CH-1:0]  care,
    input  logic [NUM_CH-1:0]  value,
    input  logic               lg_en,
    input  logic [LOGIC_W-1:0] lg_care,
    input  logic [LOGIC_W-1:0] lg_value,
    input  logic [NUM_CH-1:0]  ch_in,
    input  logic [LOGIC_W-1:0] lg_in,
    output logic               match
);

    logic [NUM_CH-1:0]  ch_miss;
    logic [LOGIC_W-1:0] lg_eff_care;
    logic [LOGIC_W-1:0] lg_miss;

    always_comb begin
        lg_eff_care = lg_en ? lg_care : '0;
        ch_miss     = (ch_in ^ value) & care;
        lg_miss     = (lg_in ^ lg_value) & lg_eff_care;
        match       = (ch_miss == '0) && (lg_miss == '0);
    end

endmodule

// File: rtl/seqtrig_edge.sv
module seqtrig_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic match,
    input  logic exit_mode,
    output logic evt
);

    typedef struct packed {
        logic prev;
        logic vld;
    } edge_regs_t;

    edge_regs_t edge_d, edge_q;

    always_comb begin
        edge_d = edge_q;
        if (exit_mode) begin
            evt = edge_q.vld && edge_q.prev && !match;
        end else begin
            evt = edge_q.vld && !edge_q.prev && match;
        end
        if (clr) begin
            edge_d.prev = 1'b0;
            edge_d.vld  = 1'b0;
        end else begin
            edge_d.prev = match;
            edge_d.vld  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q <= '0;
        end else begin
            edge_q <= edge_d;
        end
    end

endmodule

// File: rtl/seqtrig_seq.sv
module seqtrig_seq
    import seqtrig_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int HOLD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              a_evt,
    input  logic              b_evt,
    input  logic              b_none,
    input  logic [CNT_W-1:0]  count_cfg,
    input  logic [HOLD_W-1:0] hold_cfg,
    output logic              trig,
    output seq_state_e        state,
    output logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  target
);

    typedef struct packed {
        seq_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [HOLD_W-1:0] hold;
        logic              trig;
    } seq_regs_t;

    localparam seq_regs_t SEQ_RST = '{state: ST_WAIT_A, default: '0};

    seq_regs_t         seq_d, seq_q;
    logic [CNT_W-1:0]  target_w;
    logic [HOLD_W-1:0] hold_load;
    logic [CNT_W:0]    cnt_inc;

    always_comb begin
        target_w  = (count_cfg == '0) ? CNT_W'(1) : count_cfg;
        hold_load = (hold_cfg == '0) ? HOLD_W'(1) : hold_cfg;
        cnt_inc   = {1'b0, seq_q.cnt} + 1'b1;

        seq_d      = seq_q;
        seq_d.trig = 1'b0;

        if (clr) begin
            seq_d.state = ST_WAIT_A;
            seq_d.cnt   = '0;
            seq_d.hold  = '0;
        end else begin
            unique case (seq_q.state)
                ST_WAIT_A: begin
                    if (a_evt) begin
                        seq_d.cnt = '0;
                        if (b_none) begin
                            seq_d.trig  = 1'b1;
                            seq_d.state = ST_HOLDOFF;
                            seq_d.hold  = hold_load;
                        end else begin
                            seq_d.state = ST_COUNT_B;
                        end
                    end
                end
                ST_COUNT_B: begin
                    if (b_evt) begin
                        if (cnt_inc >= {1'b0, target_w}) begin
                            seq_d.trig  = 1'b1;
                            seq_d.state = ST_HOLDOFF;
                            seq_d.hold  = hold_load;
                            seq_d.cnt   = '0;
                        end else begin
                            seq_d.cnt = cnt_inc[CNT_W-1:0];
                        end
                    end
                end
                ST_HOLDOFF: begin
                    if (seq_q.hold <= HOLD_W'(1)) begin
                        seq_d.state = ST_WAIT_A;
                        seq_d.hold  = '0;
                    end else begin
                        seq_d.hold = seq_q.hold - 1'b1;
                    end
                end
                default: begin
                    seq_d.state = ST_WAIT_A;
                    seq_d.cnt   = '0;
                    seq_d.hold  = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= SEQ_RST;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign trig   = seq_q.trig;
    assign state  = seq_q.state;
    assign cnt    = seq_q.cnt;
    assign target = target_w;

endmodule

// File: rtl/seqtrig_engine.sv
module seqtrig_engine
    import seqtrig_pkg::*;
#(
    parameter int NUM_CH  = 16,
    parameter int LOGIC_W = 8,
    parameter int CNT_W   = 8,
    parameter int HOLD_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [NUM_CH-1:0]  cfg_a_care,
    input  logic [NUM_CH-1:0]  cfg_a_value,
    input  logic               cfg_a_lg_en,
    input  logic [LOGIC_W-1:0] cfg_a_lg_care,
    input  logic [LOGIC_W-1:0] cfg_a_lg_value,
    input  logic               cfg_a_exit,
    input  logic [NUM_CH-1:0]  cfg_b_care,
    input  logic [NUM_CH-1:0]  cfg_b_value,
    input  logic               cfg_b_lg_en,
    input  logic [LOGIC_W-1:0] cfg_b_lg_care,
    input  logic [LOGIC_W-1:0] cfg_b_lg_value,
    input  logic               cfg_b_exit,
    input  logic [CNT_W-1:0]   cfg_count,
    input  logic [HOLD_W-1:0]  cfg_holdoff,
    input  logic [NUM_CH-1:0]  ch_in,
    input  logic [LOGIC_W-1:0] lg_in,
    output logic               trig_out
);

    typedef struct packed {
        logic [NUM_CH-1:0]  care;
        logic [NUM_CH-1:0]  value;
        logic               lg_en;
        logic [LOGIC_W-1:0] lg_care;
        logic [LOGIC_W-1:0] lg_value;
        logic               exit_mode;
    } cond_cfg_t;

    typedef struct packed {
        cond_cfg_t [NUM_COND-1:0] cond;
        logic [CNT_W-1:0]         count;
        logic [HOLD_W-1:0]        holdoff;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr) begin
            cfg_d.cond[COND_A] = '{care: cfg_a_care, value: cfg_a_value,
                                   lg_en: cfg_a_lg_en, lg_care: cfg_a_lg_care,
                                   lg_value: cfg_a_lg_value, exit_mode: cfg_a_exit};
            cfg_d.cond[COND_B] = '{care: cfg_b_care, value: cfg_b_value,
                                   lg_en: cfg_b_lg_en, lg_care: cfg_b_lg_care,
                                   lg_value: cfg_b_lg_value, exit_mode: cfg_b_exit};
            cfg_d.count        = cfg_count;
            cfg_d.holdoff      = cfg_holdoff;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    logic [NUM_COND-1:0] match;
    logic [NUM_COND-1:0] evt;

    for (genvar gi = 0; gi < NUM_COND; gi++) begin : g_cond
        seqtrig_match #(
            .NUM_CH (NUM_CH),
            .LOGIC_W(LOGIC_W)
        ) i_match (
            .care    (cfg_q.cond[gi].care),
            .value   (cfg_q.cond[gi].value),
            .lg_en   (cfg_q.cond[gi].lg_en),
            .lg_care (cfg_q.cond[gi].lg_care),
            .lg_value(cfg_q.cond[gi].lg_value),
            .ch_in   (ch_in),
            .lg_in   (lg_in),
            .match   (match[gi])
        );

        seqtrig_edge i_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (cfg_wr),
            .match    (match[gi]),
            .exit_mode(cfg_q.cond[gi].exit_mode),
            .evt      (evt[gi])
        );
    end

    logic b_none;

    always_comb begin
        b_none = (cfg_q.cond[COND_B].care == '0) &&
                 (!cfg_q.cond[COND_B].lg_en || (cfg_q.cond[COND_B].lg_care == '0));
    end

    seq_state_e       seq_state;
    logic [CNT_W-1:0] seq_cnt;
    logic [CNT_W-1:0] seq_target;

    seqtrig_seq #(
        .CNT_W (CNT_W),
        .HOLD_W(HOLD_W)
    ) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cfg_wr),
        .a_evt    (evt[COND_A]),
        .b_evt    (evt[COND_B]),
        .b_none   (b_none),
        .count_cfg(cfg_q.count),
        .hold_cfg (cfg_q.holdoff),
        .trig     (trig_out),
        .state    (seq_state),
        .cnt      (seq_cnt),
        .target   (seq_target)
    );

endmodule

// File: rtl/seqtrig_checker.sv
module seqtrig_checker
    import seqtrig_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input seq_state_e       state,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] target,
    input logic             a_evt,
    input logic             b_evt,
    input logic             trig
);

    AST_TRIG_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !trig); // R9

    AST_TRIG_NOT_FROM_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> $past(state) != ST_HOLDOFF); // R9

    AST_TRIG_HAS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> $past(a_evt || b_evt)); // R6

    AST_B_IGNORED_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_A && b_evt && !a_evt && !cfg_wr) |=> state == ST_WAIT_A); // R6

    AST_COUNT_BELOW_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_COUNT_B |-> cnt < target); // R7

    AST_CFG_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (state == ST_WAIT_A && cnt == '0 && !trig)); // R10

endmodule

bind seqtrig_engine seqtrig_checker #(.CNT_W(CNT_W)) i_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cfg_wr(cfg_wr),
    .state (seq_state),
    .cnt   (seq_cnt),
    .target(seq_target),
    .a_evt (evt[COND_A]),
    .b_evt (evt[COND_B]),
    .trig  (trig_out)
);

// File: tb/test_seqtrig_engine.sv
module test_seqtrig_engine;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic        rst_n;
    logic        cfg_wr;
    logic [15:0] t_care [2];
    logic [15:0] t_val  [2];
    logic        t_lgen [2];
    logic [7:0]  t_lgc  [2];
    logic [7:0]  t_lgv  [2];
    logic        t_exit [2];
    logic [7:0]  t_n;
    logic [31:0] t_h;
    logic [15:0] ch_in;
    logic [7:0]  lg_in;
    logic        trig_out;

    seqtrig_engine i_seqtrig_engine (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr),
        .cfg_a_care(t_care[0]), .cfg_a_value(t_val[0]), .cfg_a_lg_en(t_lgen[0]),
        .cfg_a_lg_care(t_lgc[0]), .cfg_a_lg_value(t_lgv[0]), .cfg_a_exit(t_exit[0]),
        .cfg_b_care(t_care[1]), .cfg_b_value(t_val[1]), .cfg_b_lg_en(t_lgen[1]),
        .cfg_b_lg_care(t_lgc[1]), .cfg_b_lg_value(t_lgv[1]), .cfg_b_exit(t_exit[1]),
        .cfg_count(t_n), .cfg_holdoff(t_h),
        .ch_in(ch_in), .lg_in(lg_in), .trig_out(trig_out)
    );

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    string cur_req = "R1";
    int    trig_seen = 0;
    int    cyc = 0;
    int    last_trig_cyc = -1;
    int    min_gap = 1000000;
    bit    last_trig = 0;

    // reference model state
    bit [15:0] m_care [2];
    bit [15:0] m_val  [2];
    bit        m_lgen [2];
    bit [7:0]  m_lgc  [2];
    bit [7:0]  m_lgv  [2];
    bit        m_exit [2];
    int        m_n;
    longint    m_h;
    int        m_phase;   // 0 waiting for A, 1 counting B, 2 hold-off
    int        m_cnt;
    longint    m_hold;
    bit        m_prev [2];
    bit        m_vld;
    bit        m_trig;

    task automatic check(input string req, input int act, input int exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit pat_hit(input int k, input bit [15:0] ch, input bit [7:0] lg);
        bit ok;
        ok = 1'b1;
        for (int i = 0; i < 16; i++) begin
            if (m_care[k][i] && (ch[i] != m_val[k][i])) ok = 1'b0;
        end
        if (m_lgen[k]) begin
            for (int i = 0; i < 8; i++) begin
                if (m_lgc[k][i] && (lg[i] != m_lgv[k][i])) ok = 1'b0;
            end
        end
        return ok;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            m_care[k] = 0; m_val[k] = 0; m_lgen[k] = 0;
            m_lgc[k] = 0; m_lgv[k] = 0; m_exit[k] = 0; m_prev[k] = 0;
        end
        m_n = 0; m_h = 0; m_phase = 0; m_cnt = 0; m_hold = 0; m_vld = 0; m_trig = 0;
    endtask

    task automatic model_step(input bit [15:0] ch, input bit [7:0] lg, input bit wr);
        bit hit [2];
        bit ev  [2];
        bit b_ignores_all;
        int need;
        longint hl;
        m_trig = 0;
        if (wr) begin
            for (int k = 0; k < 2; k++) begin
                m_care[k] = t_care[k]; m_val[k] = t_val[k]; m_lgen[k] = t_lgen[k];
                m_lgc[k] = t_lgc[k]; m_lgv[k] = t_lgv[k]; m_exit[k] = t_exit[k];
            end
            m_n = int'(t_n); m_h = longint'(t_h);
            m_phase = 0; m_cnt = 0; m_hold = 0; m_vld = 0;
        end else begin
            for (int k = 0; k < 2; k++) begin
                hit[k] = pat_hit(k, ch, lg);
                ev[k]  = m_vld && (m_exit[k] ? (m_prev[k] && !hit[k]) : (!m_prev[k] && hit[k]));
            end
            b_ignores_all = (m_care[1] == 0) && (!m_lgen[1] || m_lgc[1] == 0);
            need = (m_n == 0) ? 1 : m_n;
            hl   = (m_h == 0) ? 1 : m_h;
            if (m_phase == 0) begin
                if (ev[0]) begin
                    m_cnt = 0;
                    if (b_ignores_all) begin
                        m_trig = 1; m_phase = 2; m_hold = hl;
                    end else begin
                        m_phase = 1;
                    end
                end
            end else if (m_phase == 1) begin
                if (ev[1]) begin
                    m_cnt++;
                    if (m_cnt >= need) begin
                        m_trig = 1; m_phase = 2; m_hold = hl; m_cnt = 0;
                    end
                end
            end else begin
                if (m_hold <= 1) m_phase = 0;
                else m_hold--;
            end
            for (int k = 0; k < 2; k++) m_prev[k] = hit[k];
            m_vld = 1;
        end
    endtask

    // one clock: drive at negedge, step the model, compare after the edge
    task automatic tick(input logic [15:0] ch, input logic [7:0] lg, input bit wr);
        ch_in  = ch;
        lg_in  = lg;
        cfg_wr = wr;
        model_step(ch, lg, wr);
        @(posedge clk);
        @(negedge clk);
        cyc++;
        check(cur_req, int'(trig_out), int'(m_trig), "trig_out vs model");
        if (trig_out) begin
            check("R9", int'(last_trig), 0, "pulse longer than one clock");
            trig_seen++;
            if (last_trig_cyc >= 0 && (cyc - last_trig_cyc) < min_gap) min_gap = cyc - last_trig_cyc;
            last_trig_cyc = cyc;
        end
        last_trig = trig_out;
        cfg_wr = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] ch);
        tick(ch, 8'h00, 1'b0);
        tick(16'h0000, 8'h00, 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(16'h0000, 8'h00, 1'b0);
    endtask

    task automatic clear_cfg();
        for (int k = 0; k < 2; k++) begin
            t_care[k] = 0; t_val[k] = 0; t_lgen[k] = 0;
            t_lgc[k] = 0; t_lgv[k] = 0; t_exit[k] = 0;
        end
        t_n = 0; t_h = 0;
    endtask

    task automatic write_cfg();
        tick(16'h0000, 8'h00, 1'b1);
        last_trig_cyc = -1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int base;
        rst_n = 1'b0; cfg_wr = 1'b0; ch_in = 0; lg_in = 0;
        clear_cfg();
        model_reset();
        repeat (3) @(negedge clk);
        check("R1", int'(trig_out), 0, "trig_out during reset");
        rst_n = 1'b1;
        cur_req = "R1";
        tick(16'hFFFF, 8'hFF, 1'b0);
        tick(16'h0000, 8'h00, 1'b0);
        tick(16'h00FF, 8'h0F, 1'b0);
        check("R1", trig_seen, 0, "triggers after reset");

        // R6: A on ch0 rising, B on ch1 rising, N=3
        cur_req = "R6";
        clear_cfg();
        t_care[0] = 16'h0001; t_val[0] = 16'h0001;
        t_care[1] = 16'h0002; t_val[1] = 16'h0002;
        t_n = 8'd3; t_h = 32'd4;
        write_cfg();
        idle(2);
        base = trig_seen;
        pulse(16'h0002); pulse(16'h0002);
        check("R6", trig_seen - base, 0, "B before A ignored");
        pulse(16'h0001);
        pulse(16'h0002); pulse(16'h0002);
        check("R6", trig_seen - base, 0, "two of three B");
        pulse(16'h0002);
        check("R6", trig_seen - base, 1, "third B fires");
        idle(6);
        pulse(16'h0003);
        pulse(16'h0002); pulse(16'h0002);
        check("R6", trig_seen - base, 1, "B with A not counted");
        pulse(16'h0002);
        check("R6", trig_seen - base, 2, "third later B fires");

        // R7: count of 0 acts as 1; second A does not restart
        cur_req = "R7";
        t_n = 8'd0; t_h = 32'd1;
        write_cfg();
        idle(2);
        base = trig_seen;
        pulse(16'h0001); pulse(16'h0002);
        check("R7", trig_seen - base, 1, "count 0 fires on first B");
        t_n = 8'd2;
        write_cfg();
        idle(2);
        pulse(16'h0001); pulse(16'h0002); pulse(16'h0001); pulse(16'h0002);
        check("R7", trig_seen - base, 2, "A during count keeps count");

        // R8 + R4: B ignores everything, A Enter on ch0
        cur_req = "R8";
        clear_cfg();
        t_care[0] = 16'h0001; t_val[0] = 16'h0001; t_h = 32'd2;
        t_lgen[1] = 1'b1; t_lgc[1] = 8'h00;
        write_cfg();
        idle(2);
        base = trig_seen;
        tick(16'h0001, 8'h00, 1'b0);
        check("R4", int'(trig_out), 1, "enter edge fires next clock");
        tick(16'h0001, 8'h00, 1'b0);
        tick(16'h0000, 8'h00, 1'b0);
        check("R8", trig_seen - base, 1, "A alone fires");

        // R5: Exit mode on ch2 high
        cur_req = "R5";
        clear_cfg();
        t_care[0] = 16'h0004; t_val[0] = 16'h0004; t_exit[0] = 1'b1; t_h = 32'd1;
        write_cfg();
        idle(2);
        base = trig_seen;
        tick(16'h0004, 8'h00, 1'b0);
        tick(16'h0004, 8'h00, 1'b0);
        check("R5", trig_seen - base, 0, "entering match no event in exit mode");
        tick(16'h0000, 8'h00, 1'b0);
        check("R5", int'(trig_out), 1, "leaving match fires");

        // R2 + R3: ch15 must be low, logic low nibble must equal 5
        cur_req = "R3";
        clear_cfg();
        t_care[0] = 16'h8000; t_val[0] = 16'h0000;
        t_lgen[0] = 1'b1; t_lgc[0] = 8'h0F; t_lgv[0] = 8'h05; t_h = 32'd1;
        write_cfg();
        base = trig_seen;
        tick(16'h8000, 8'h05, 1'b0); tick(16'h8000, 8'h05, 1'b0);
        check("R2", trig_seen - base, 0, "low-required channel high blocks match");
        tick(16'h0000, 8'h05, 1'b0);
        check("R2", trig_seen - base, 1, "full match fires");
        tick(16'h0000, 8'hF0, 1'b0); tick(16'h0000, 8'hF0, 1'b0);
        tick(16'h0000, 8'hF5, 1'b0);
        check("R3", trig_seen - base, 2, "logic bits outside care ignored");
        t_lgen[0] = 1'b0;
        write_cfg();
        tick(16'h0000, 8'hF0, 1'b0); tick(16'h0000, 8'h05, 1'b0);
        tick(16'h0000, 8'h00, 1'b0); tick(16'h0000, 8'h05, 1'b0);
        check("R3", trig_seen - base, 2, "disabled logic group has no effect");

        // R9: hold-off 10 with A every 3 clocks
        cur_req = "R9";
        clear_cfg();
        t_care[0] = 16'h0001; t_val[0] = 16'h0001; t_h = 32'd10;
        write_cfg();
        idle(2);
        base = trig_seen;
        min_gap = 1000000;
        for (int r = 0; r < 10; r++) begin
            tick(16'h0001, 8'h00, 1'b0);
            idle(2);
        end
        check("R9", trig_seen - base, 3, "triggers under hold-off");
        check("R9", min_gap, 12, "gap between triggers");

        // R10: write mid-count clears progress
        cur_req = "R10";
        clear_cfg();
        t_care[0] = 16'h0001; t_val[0] = 16'h0001;
        t_care[1] = 16'h0002; t_val[1] = 16'h0002;
        t_n = 8'd3; t_h = 32'd1;
        write_cfg();
        idle(2);
        base = trig_seen;
        pulse(16'h0001); pulse(16'h0002);
        write_cfg();
        pulse(16'h0002); pulse(16'h0002); pulse(16'h0002);
        check("R10", trig_seen - base, 0, "write returns to waiting for A");
        pulse(16'h0001); pulse(16'h0002); pulse(16'h0002); pulse(16'h0002);
        check("R10", trig_seen - base, 1, "fresh sequence fires");
        tick(16'h0001, 8'h00, 1'b1);
        tick(16'h0001, 8'h00, 1'b0);
        check("R10", int'(trig_out), 0, "no event on first clock after write");

        // mixed patterns and modes against the model
        cur_req = "R4";
        for (int i = 0; i < 3000; i++) begin
            if (i % 300 == 0) begin
                for (int k = 0; k < 2; k++) begin
                    t_care[k] = 16'($urandom_range(0, 15));
                    t_val[k]  = 16'($urandom_range(0, 15));
                    t_lgen[k] = 1'($urandom_range(0, 1));
                    t_lgc[k]  = 8'($urandom_range(0, 3));
                    t_lgv[k]  = 8'($urandom_range(0, 3));
                    t_exit[k] = 1'($urandom_range(0, 1));
                end
                t_n = 8'($urandom_range(0, 3));
                t_h = 32'($urandom_range(0, 5));
                cur_req = (i % 600 == 0) ? "R4" : "R5";
                write_cfg();
            end
            tick(16'($urandom_range(0, 15)), 8'($urandom_range(0, 3)), 1'b0);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule